// File: doc/BRIEF.md
# Transmit Interrupt Coalescing Unit

This block sits between the transmit DMA engine and the CPU interrupt line. Every time the DMA engine finishes copying a frame out of memory, it sends a one-cycle completion pulse. The block records that pulse in a sticky pending bit, and it decides when the pending state may drive the interrupt request. Software acknowledges the pending state by writing a one, which reaches the block as a single-cycle strobe.

Two ways of reducing the interrupt rate are provided:

- **Coalescing.** When either the event threshold or the tick timeout is nonzero, the request is held back. It is let through once the threshold number of events has been counted, or once the timeout has run out, whichever happens first. The timeout runs on a prescaled tick input and is measured from the first event that follows the last delivery.
- **Last-frame-only mode.** In this mode, only completions flagged as the end of a sequence are counted as events.

When both the threshold and the timeout are zero, every event raises the request at once. The request always obeys a global enable and a transmit mask.

Top module: `tx_irq_coalesce`

## Requirements
- R1: While `rst` is high, `status_o` and `irq_o` are 0 after every clock edge.
- R2: A qualifying event sets `status_o` at the edge that samples it. An event is `done_i`=1 when `last_only_i`=0, or `done_i`=1 with `done_last_i`=1 when `last_only_i`=1. A completion with `done_last_i`=0 in last-only mode leaves `status_o` unchanged.
- R3: `ack_i`=1 clears `status_o` at the edge that samples it, unless a qualifying event is sampled at the same edge, in which case `status_o` stays 1.
- R4: `irq_o` is 1 after an edge only if that edge sampled `glob_en_i`=1, `tx_mask_i`=0 and a pending state that has been released. Changes to the enable or the mask take effect at the next edge.
- R5: With `thresh_i`=0 and `tmo_i`=0, `irq_o` rises at the same edge as `status_o`.
- R6: With `thresh_i`=N>0, the request is released at the edge that samples the N-th qualifying event counted since the last release. Idle cycles between events do not reset the count.
- R7: With `tmo_i`=T>0, a window opens at the edge that samples the first qualifying event after a release. The request is released at the edge that samples the T-th `tick_i` pulse after that edge. A tick in the same cycle as the opening event is not counted, and later events do not restart the window.
- R8: When both limits are nonzero, the request is released by whichever limit is reached first.
- R9: Events that arrive after a release but before the acknowledge are not counted. After the acknowledge, counting and timing start again from zero. An event sampled together with the acknowledge counts as the first event of the new window.
- R10: The acknowledge drops `irq_o` at the edge that samples it. This includes the case where the pending bit stays set because an event arrived in the same cycle, as long as that event does not release the request on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Transmit frame copy finished (one-cycle pulse) |
| done_last_i | input | 1 | The finished frame ends a sequence |
| glob_en_i | input | 1 | Global interrupt enable |
| tx_mask_i | input | 1 | Transmit interrupt mask (1 = masked) |
| thresh_i | input | CNT_W | Event count limit (0 = no count limit) |
| tmo_i | input | TMO_W | Timeout in ticks (0 = no time limit) |
| last_only_i | input | 1 | Count only end-of-sequence completions |
| tick_i | input | 1 | Prescaled timer tick |
| ack_i | input | 1 | Write-one-to-clear strobe for the pending bit |
| status_o | output | 1 | Sticky transmit interrupt pending bit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every result of this block is a flop that is updated from the inputs sampled at a single edge. The pending bit and the request therefore answer an event, a tick or an acknowledge at that same edge, and they answer a change of enable or mask one edge later. The bench drives each stimulus just after a rising edge, waits for exactly one further edge, and then compares both outputs against a value derived from the event index or the tick index. It sweeps thresholds and timeouts from 1 to 5, and before the limit is reached it checks that the request is still low.

// File: rtl/tic_pkg.sv
package tic_pkg;
  typedef struct packed {
    logic pend;
    logic rel;
    logic req;
  } tic_flags_t;
endpackage

// File: rtl/tic_event_qual.sv
module tic_event_qual (
  input  logic done_i,
  input  logic last_i,
  input  logic last_only_i,
  output logic ev_o
);
  always_comb ev_o = done_i & (~last_only_i | last_i);
endmodule

// File: rtl/tic_window.sv
module tic_window #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             ev_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMO_W-1:0] TMO_MAX = {TMO_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmr_q;
  logic             armed_q;
  logic [CNT_W:0]   cnt_sum;
  logic [TMO_W:0]   tmr_sum;
  logic             hit_cnt, hit_tmr;

  always_comb begin
    cnt_sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, ev_i};
    tmr_sum = {1'b0, tmr_q} + {{TMO_W{1'b0}}, 1'b1};
    hit_cnt = run_i & ev_i & (thresh_i != '0) & (cnt_sum >= {1'b0, thresh_i});
    hit_tmr = run_i & armed_q & tick_i & (tmo_i != '0) & (tmr_sum >= {1'b0, tmo_i});
    hit_o   = hit_cnt | hit_tmr;
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i || hit_o) begin
      cnt_q   <= '0;
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (ev_i && cnt_q != CNT_MAX) cnt_q <= cnt_sum[CNT_W-1:0];
      if (armed_q && tick_i && tmr_q != TMO_MAX) tmr_q <= tmr_sum[TMO_W-1:0];
      armed_q <= armed_q | ev_i;
    end
  end
endmodule

// File: rtl/tic_irq_state.sv
module tic_irq_state
  import tic_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  input  logic ack_i,
  input  logic coal_i,
  input  logic hit_i,
  input  logic en_i,
  input  logic mask_i,
  output logic run_o,
  output logic pend_o,
  output logic req_o
);
  tic_flags_t cur, nxt;
  logic       held;

  always_comb begin
    held     = cur.rel & ~ack_i;
    nxt.pend = ev_i | (cur.pend & ~ack_i);
    run_o    = nxt.pend & ~held;
    nxt.rel  = coal_i & nxt.pend & (hit_i | held);
    nxt.req  = en_i & ~mask_i & nxt.pend & (~coal_i | nxt.rel);
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign pend_o = cur.pend;
  assign req_o  = cur.req;
endmodule

// File: rtl/tx_irq_coalesce.sv
module tx_irq_coalesce #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic             done_last_i,
  input  logic             glob_en_i,
  input  logic             tx_mask_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             last_only_i,
  input  logic             tick_i,
  input  logic             ack_i,
  output logic             status_o,
  output logic             irq_o
);
  logic ev, run, hit, coal;

  assign coal = (thresh_i != '0) | (tmo_i != '0);

  tic_event_qual u_qual (
    .done_i      (done_i),
    .last_i      (done_last_i),
    .last_only_i (last_only_i),
    .ev_o        (ev)
  );

  tic_window #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .ev_i     (ev),
    .tick_i   (tick_i),
    .thresh_i (thresh_i),
    .tmo_i    (tmo_i),
    .hit_o    (hit)
  );

  tic_irq_state u_state (
    .clk    (clk),
    .rst    (rst),
    .ev_i   (ev),
    .ack_i  (ack_i),
    .coal_i (coal),
    .hit_i  (hit),
    .en_i   (glob_en_i),
    .mask_i (tx_mask_i),
    .run_o  (run),
    .pend_o (status_o),
    .req_o  (irq_o)
  );
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             done_i,
  input logic             done_last_i,
  input logic             glob_en_i,
  input logic             tx_mask_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic [TMO_W-1:0] tmo_i,
  input logic             last_only_i,
  input logic             tick_i,
  input logic             ack_i,
  input logic             status_o,
  input logic             irq_o
);
  logic qual;
  assign qual = done_i & (~last_only_i | done_last_i);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!status_o && !irq_o));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    qual |=> status_o);

  a_r2_nonlast_ignored: assert property (@(posedge clk) disable iff (rst)
    (!status_o && !qual) |=> !status_o);

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !qual) |=> !status_o);

  a_r4_gated: assert property (@(posedge clk) disable iff (rst)
    (!glob_en_i || tx_mask_i) |=> !irq_o);

  a_r4_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> status_o);

  a_r5_immediate: assert property (@(posedge clk) disable iff (rst)
    (thresh_i == '0 && tmo_i == '0 && glob_en_i && !tx_mask_i && qual) |=> irq_o);
endmodule

bind tx_irq_coalesce tic_checker #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/sim_tx_irq_coalesce.sv
module sim_tx_irq_coalesce;
  localparam int CNT_W = 8;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_i = 0, done_last_i = 0, glob_en_i = 1, tx_mask_i = 0;
  logic [CNT_W-1:0] thresh_i = '0;
  logic [TMO_W-1:0] tmo_i = '0;
  logic last_only_i = 0, tick_i = 0, ack_i = 0;
  logic status_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tx_irq_coalesce #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rst(rst), .done_i(done_i), .done_last_i(done_last_i),
    .glob_en_i(glob_en_i), .tx_mask_i(tx_mask_i), .thresh_i(thresh_i),
    .tmo_i(tmo_i), .last_only_i(last_only_i), .tick_i(tick_i),
    .ack_i(ack_i), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic st_exp, input logic irq_exp);
    n_chk++;
    if (status_o !== st_exp || irq_o !== irq_exp) begin
      n_bad++;
      $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
               tag, status_o, irq_o, st_exp, irq_exp);
    end
  endtask

  // Drive one cycle of pulses just after an edge, then advance past the next edge.
  task automatic cyc(input logic d, input logic l, input logic a, input logic t);
    done_i = d; done_last_i = l; ack_i = a; tick_i = t;
    @(posedge clk); #1;
    done_i = 0; done_last_i = 0; ack_i = 0; tick_i = 0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(posedge clk); #1;
    cyc(1, 1, 0, 1);
    chk("R1 reset", 0, 0);
    rst = 0;

    // Immediate mode
    cyc(1, 0, 0, 0); chk("R5 immediate event", 1, 1);
    cyc(0, 0, 0, 0); chk("R2 sticky", 1, 1);
    cyc(0, 0, 1, 0); chk("R3 ack clears", 0, 0);

    // Mask and enable
    tx_mask_i = 1;
    cyc(1, 0, 0, 0); chk("R4 masked", 1, 0);
    tx_mask_i = 0;
    cyc(0, 0, 0, 0); chk("R4 unmask next edge", 1, 1);
    glob_en_i = 0;
    cyc(0, 0, 0, 0); chk("R4 disabled", 1, 0);
    glob_en_i = 1;
    cyc(0, 0, 1, 0); chk("R3 ack", 0, 0);

    // Last-only mode
    last_only_i = 1;
    cyc(1, 0, 0, 0); chk("R2 nonlast ignored", 0, 0);
    cyc(1, 1, 0, 0); chk("R2 last counted", 1, 1);
    cyc(0, 0, 1, 0); chk("R3 ack", 0, 0);
    last_only_i = 0;

    // Count threshold sweep
    for (int n = 1; n <= 5; n++) begin
      thresh_i = CNT_W'(n); tmo_i = '0;
      for (int k = 1; k <= n; k++) begin
        cyc(1, 0, 0, 1);
        chk($sformatf("R6 thr=%0d ev=%0d", n, k), 1, k == n);
        if (n % 2 == 0 && k < n) begin
          cyc(0, 0, 0, 0); chk($sformatf("R6 gap thr=%0d", n), 1, 0);
        end
      end
      cyc(0, 0, 0, 0); chk("R6 held", 1, 1);
      cyc(0, 0, 1, 0); chk("R10 ack drops", 0, 0);
    end

    // Timeout sweep
    for (int t = 1; t <= 5; t++) begin
      thresh_i = '0; tmo_i = TMO_W'(t);
      cyc(1, 0, 0, 1); chk($sformatf("R7 tmo=%0d open", t), 1, 0);
      for (int j = 1; j <= t; j++) begin
        cyc(0, 0, 0, 1);
        chk($sformatf("R7 tmo=%0d tick=%0d", t, j), 1, j == t);
      end
      cyc(0, 0, 1, 0); chk("R10 ack drops", 0, 0);
    end

    // Later events do not restart the window
    thresh_i = '0; tmo_i = 16'd3;
    cyc(1, 0, 0, 0); chk("R7 open", 1, 0);
    cyc(0, 0, 0, 1); chk("R7 tick1", 1, 0);
    cyc(1, 0, 0, 1); chk("R7 ev+tick2", 1, 0);
    cyc(0, 0, 0, 1); chk("R7 tick3 fires", 1, 1);
    cyc(0, 0, 1, 0); chk("R10 ack", 0, 0);

    // Whichever first: timer wins, then count wins
    thresh_i = 8'd3; tmo_i = 16'd2;
    cyc(1, 0, 0, 1); chk("R8 open", 1, 0);
    cyc(0, 0, 0, 1); chk("R8 tick1", 1, 0);
    cyc(1, 0, 0, 1); chk("R8 timer first", 1, 1);
    cyc(0, 0, 1, 0); chk("R10 ack", 0, 0);
    thresh_i = 8'd2; tmo_i = 16'd10;
    cyc(1, 0, 0, 1); chk("R8 ev1", 1, 0);
    cyc(1, 0, 0, 1); chk("R8 count first", 1, 1);
    cyc(0, 0, 1, 0); chk("R10 ack", 0, 0);

    // Restart after release
    thresh_i = 8'd2; tmo_i = '0;
    cyc(1, 0, 0, 0); chk("R9 ev1", 1, 0);
    cyc(1, 0, 0, 0); chk("R9 release", 1, 1);
    cyc(1, 0, 0, 0); chk("R9 ev while released", 1, 1);
    cyc(0, 0, 1, 0); chk("R9 ack", 0, 0);
    cyc(1, 0, 0, 0); chk("R9 recount ev1", 1, 0);
    cyc(1, 0, 0, 0); chk("R9 recount ev2", 1, 1);
    cyc(1, 0, 1, 0); chk("R10 ack with event", 1, 0);
    cyc(1, 0, 0, 0); chk("R9 ack event counted", 1, 1);
    cyc(0, 0, 1, 0); chk("R3 final ack", 0, 0);

    summary();
  end
endmodule